// File: doc/BRIEF.md
# Serial EEPROM write-path slave

This block is the receive side of a two-wire serial memory that follows the I2C protocol. It watches SCL and SDA, finds START and STOP, and accepts a write addressed to it. A write has three parts: a device address with the direction bit clear, one byte that sets the word pointer, and one or more data bytes. The data bytes go into a page buffer, and the buffer is written to the storage array only after the host ends the transfer with STOP and a timed programming interval has passed.

While that interval runs, the block does not answer on the bus. A host finds out that programming has finished by sending START and the device address again and again until the address is acknowledged. A protect input, sampled once per transaction, can refuse a write. Both bus lines are open drain. The block sees each line as a plain input and pulls SDA low through an enable. The array's read side is brought out as a combinational lookup port, so that the rest of the chip can see what has been stored.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, every array location holds 0xFF and SDA is not pulled low.
- R2: Only the byte {4'b1010, SEL, 0} is acknowledged as a device address, with SEL = 3'b000 by default. Any other address byte is not acknowledged, and so is an address with the direction bit set to 1. After an address that is not acknowledged, the block ignores every byte until the next START.
- R3: For a single-byte write (address 0xA0, word pointer, data, STOP), each of the three bytes is acknowledged. After the programming interval, the data byte is stored at the pointer location.
- R4: Each stored data byte advances only the low 4 bits of the pointer, so the bytes of one write stay inside one 16-byte page. Locations in that page that received no byte, and locations outside the page, keep their contents.
- R5: If more than 16 data bytes arrive before STOP, the pointer wraps within the page and the later bytes replace the earlier ones. Byte k lands at page offset (start + k) mod 16.
- R6: The array does not change until the programming interval of WR_CYCLES clocks that follows STOP has ended. The interval starts only when STOP arrives after at least one accepted data byte.
- R7: During the programming interval the block acknowledges nothing, including its own device address. Once the interval is over, the device address is acknowledged again.
- R8: WP is sampled on the SCL falling edge that ends the acknowledge of the word-pointer byte. If WP is high at that edge, the first data byte is not acknowledged, nothing is stored and no programming interval starts.
- R9: Changes on WP after that sampling edge have no effect. A write whose WP sample was low completes even if WP rises during its data bytes.
- R10: A STOP that comes before any data byte, or a repeated START in the middle of a transaction, discards the pending write. No programming interval starts and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Level sensed on the serial clock line |
| sda_i | input | 1 | Level sensed on the serial data line |
| wp_i | input | 1 | Write protect, active high |
| sda_oe | output | 1 | When high, pull SDA low (acknowledge) |
| look_addr | input | ADDR_W | Array location to look up |
| look_data | output | 8 | Contents of the location at look_addr |

## Verification
Four properties are checked on every clock. The line stays released for the whole programming interval. An interval can begin only on a STOP that was just detected. The page bits of the pointer hold while data bytes stream in. A protected data byte is never acknowledged and sends the block into the ignore state. Only the bench scenarios can show the effects across a whole transaction. These are page wrap and overwrite, which locations end up holding which bytes, an unchanged array part-way through programming, the acknowledge pattern seen by a polling host, and the exact edge at which WP is taken. The bench sweeps the lookup port on every clock against its own model of the array.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  parameter int WR_CYCLES = 1500,
  parameter logic [2:0] SEL = 3'b000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wp_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] look_addr,
  output logic [7:0]        look_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TW    = $clog2(WR_CYCLES + 1);
  localparam logic [3:0] TYPE_CODE = 4'b1010;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_ADR, S_DATA, S_SKIP} st_t;

  logic [2:0]        scl_s, sda_s;
  st_t               st;
  logic [3:0]        cnt;
  logic [7:0]        sh;
  logic [ADDR_W-1:0] ptr;
  logic [PAGE-1:0]   mask;
  logic              wp_lat, busy;
  logic [TW-1:0]     timer;
  logic [7:0]        pbuf [PAGE];
  logic [7:0]        mem  [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end

  wire scl_rise  = scl_s[1] & ~scl_s[2];
  wire scl_fall  = ~scl_s[1] & scl_s[2];
  wire start_det = scl_s[1] & scl_s[2] & sda_s[2] & ~sda_s[1];
  wire stop_det  = scl_s[1] & scl_s[2] & ~sda_s[2] & sda_s[1];
  wire active    = (st == S_DEV) || (st == S_ADR) || (st == S_DATA);
  wire byte_done = !start_det && !stop_det && active && scl_fall && (cnt == 4'd8);
  wire dev_hit   = (sh[7:1] == {TYPE_CODE, SEL}) && !sh[0] && !busy;
  wire wr_byte   = byte_done && (st == S_DATA) && !wp_lat;
  wire commit    = busy && (timer == '0);
  wire ack_now   = (st == S_DEV && dev_hit) || (st == S_ADR) || (st == S_DATA && !wp_lat);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      ptr    <= '0;
      mask   <= '0;
      wp_lat <= 1'b0;
      sda_oe <= 1'b0;
      busy   <= 1'b0;
      timer  <= '0;
    end else begin
      if (busy) begin
        if (commit) begin
          busy <= 1'b0;
          mask <= '0;
        end else timer <= timer - 1'b1;
      end
      if (start_det) begin
        st     <= S_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
        wp_lat <= 1'b0;
      end else if (stop_det) begin
        if (st == S_DATA && mask != '0 && !wp_lat) begin
          busy  <= 1'b1;
          timer <= TW'(WR_CYCLES - 1);
        end
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (active) begin
        if (scl_rise && cnt < 4'd8) begin
          sh  <= {sh[6:0], sda_s[1]};
          cnt <= cnt + 4'd1;
        end else if (byte_done) begin
          cnt    <= 4'd9;
          sda_oe <= ack_now;
          case (st)
            S_DEV: st <= dev_hit ? S_ADR : S_SKIP;
            S_ADR: begin
              st   <= S_DATA;
              ptr  <= sh[ADDR_W-1:0];
              mask <= '0;
            end
            default: begin
              if (wp_lat) st <= S_SKIP;
              else begin
                mask[ptr[PAGE_W-1:0]] <= 1'b1;
                ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
              end
            end
          endcase
        end else if (scl_fall && cnt == 4'd9) begin
          sda_oe <= 1'b0;
          cnt    <= '0;
          if (st == S_DATA && mask == '0) wp_lat <= wp_i;
        end
      end
    end

  always_ff @(posedge clk)
    if (wr_byte) pbuf[ptr[PAGE_W-1:0]] <= sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int j = 0; j < PAGE; j++)
        if (mask[j]) mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(j)}] <= pbuf[j];
    end

  assign look_data = mem[look_addr];

  p_silent_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  p_cycle_from_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  p_page_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && $past(st) == S_DATA) |->
      ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

  p_wp_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == S_DATA && wp_lat) |=> (!sda_oe && st == S_SKIP));
endmodule

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, host_sda = 1'b1, wp = 1'b0;
  logic sweep_en = 1'b1;
  logic [7:0] sweep_a = '0, probe_a = '0;
  wire  [7:0] look_addr = sweep_en ? sweep_a : probe_a;
  logic sda_oe;
  logic [7:0] look_data;
  wire  sda_bus = host_sda & ~sda_oe;

  logic [7:0] model [256];
  bit settled = 1'b1;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  eeprom_page_writer i_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .wp_i(wp),
    .sda_oe(sda_oe), .look_addr(look_addr), .look_data(look_data));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // R1 R6: whole array compared with the model on every clock while no write is pending
  always @(negedge clk)
    if (rst_n && sweep_en) begin
      if (settled) chk(look_data === model[sweep_a], "R6 array sweep", look_data, model[sweep_a]);
      sweep_a <= sweep_a + 8'd1;
    end

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask
  task automatic go_start();
    host_sda = 1'b1; q(); scl = 1'b1; q(); host_sda = 1'b0; q(); scl = 1'b0; q();
  endtask
  task automatic go_stop();
    host_sda = 1'b0; q(); scl = 1'b1; q(); host_sda = 1'b1; q();
  endtask
  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    end
    host_sda = 1'b1; q(); scl = 1'b1; q(); ack = !sda_bus; q(); scl = 1'b0; q();
  endtask
  task automatic poll(output int nacks);
    bit a;
    nacks = 0;
    for (int k = 0; k < 40; k++) begin
      go_start(); send(8'hA0, a); go_stop();
      if (a) break;
      nacks++;
    end
  endtask
  task automatic apply(input logic [7:0] a, input logic [7:0] d[$]);
    for (int k = 0; k < d.size(); k++)
      model[{a[7:4], 4'(a[3:0] + 4'(k))}] = d[k];
  endtask
  task automatic write_all(input logic [7:0] a, input logic [7:0] d[$], input string tag);
    bit ad, aa, ab;
    int acks = 0, n;
    settled = 1'b0;
    go_start(); send(8'hA0, ad); send(a, aa);
    for (int k = 0; k < d.size(); k++) begin send(d[k], ab); if (ab) acks++; end
    go_stop();
    chk(ad && aa, {tag, " address acks"}, {ad, aa}, 3);
    chk(acks == d.size(), {tag, " data acks"}, acks, d.size());
    poll(n);
    chk(n > 0 && n < 40, {tag, " R7 polls NACKed then ACK"}, n, 1);
    apply(a, d);
    settled = 1'b1;
  endtask
  task automatic probe(input logic [7:0] a, input logic [7:0] exp, input string tag);
    sweep_en = 1'b0; probe_a = a;
    @(negedge clk);
    chk(look_data === exp, tag, look_data, exp);
    sweep_en = 1'b1;
  endtask
  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      report();
    end
  end

  initial begin
    bit a, b, c;
    int n;
    logic [7:0] d[$];
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sda_oe == 1'b0, "R1 SDA released after reset", sda_oe, 0);
    probe(8'h00, 8'hFF, "R1 erased low end");
    probe(8'hFF, 8'hFF, "R1 erased high end");
    repeat (300) @(negedge clk);

    // R3 R6 R7: single byte, checked part-way through programming
    settled = 1'b0;
    go_start(); send(8'hA0, a); send(8'h35, b); send(8'hA5, c); go_stop();
    chk(a && b && c, "R3 byte write acks", {a, b, c}, 7);
    go_start(); send(8'hA0, a);
    chk(!a, "R7 address NACK while busy", a, 0);
    probe(8'h35, 8'hFF, "R6 old value during programming");
    go_stop();
    poll(n);
    chk(n < 40, "R7 ACK after programming", n, 0);
    d = '{8'hA5}; apply(8'h35, d); settled = 1'b1;
    probe(8'h35, 8'hA5, "R3 byte stored");

    // R2: foreign and read addresses ignored
    go_start(); send(8'hA2, a); send(8'h10, b); send(8'h55, c); go_stop();
    chk(!a && !b && !c, "R2 foreign address and bytes NACKed", {a, b, c}, 0);
    go_start(); send(8'hA1, a); go_stop();
    chk(!a, "R2 direction bit 1 NACKed", a, 0);
    poll(n);
    chk(n == 0, "R2 no programming after foreign address", n, 0);
    probe(8'h10, 8'hFF, "R2 array untouched");

    // R4: page write crossing page end
    d = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
    write_all(8'h4C, d, "R4 page");
    probe(8'h41, 8'h06, "R4 wrapped to page start");
    probe(8'h50, 8'hFF, "R4 next page untouched");
    probe(8'h42, 8'hFF, "R4 unsent offset untouched");

    // R5: 18 bytes overwrite first two
    d = {};
    for (int k = 0; k < 18; k++) d.push_back(8'(8'h20 + k));
    write_all(8'h82, d, "R5 overflow");
    probe(8'h82, 8'h30, "R5 first byte overwritten");
    probe(8'h83, 8'h31, "R5 second byte overwritten");
    probe(8'h84, 8'h22, "R5 third byte kept");

    // R8: protect high at strobe
    wp = 1'b1;
    go_start(); send(8'hA0, a); send(8'h20, b); send(8'h77, c); go_stop();
    wp = 1'b0;
    chk(a && b && !c, "R8 data NACK under protect", {a, b, c}, 6);
    poll(n);
    chk(n == 0, "R8 no programming interval", n, 0);
    probe(8'h20, 8'hFF, "R8 array unchanged");

    // R9: protect rises after strobe
    settled = 1'b0;
    go_start(); send(8'hA0, a); send(8'h21, b);
    wp = 1'b1;
    send(8'h66, c);
    chk(a && b && c, "R9 late protect ignored", {a, b, c}, 7);
    send(8'h67, c); go_stop();
    wp = 1'b0;
    chk(c, "R9 second byte acked", c, 1);
    poll(n);
    d = '{8'h66, 8'h67}; apply(8'h21, d); settled = 1'b1;
    probe(8'h22, 8'h67, "R9 write completed");

    // R10: early STOP and repeated START
    go_start(); send(8'hA0, a); send(8'h30, b); go_stop();
    poll(n);
    chk(n == 0, "R10 STOP before data starts nothing", n, 0);
    go_start(); send(8'hA0, a); send(8'h31, b); send(8'h12, c);
    go_start(); go_stop();
    poll(n);
    chk(n == 0, "R10 repeated START abandons write", n, 0);
    probe(8'h31, 8'hFF, "R10 array unchanged");

    repeat (300) @(negedge clk);
    done = 1'b1;
    report();
  end
endmodule